// File: doc/BRIEF.md
# BCD Hour Counter with 12/24 Mode

This block holds the hour field of a real-time clock. Each one-cycle pulse on the hour-carry input, coming from the minutes stage, moves the stored hour forward by one. The hour is kept as packed BCD. A mode input selects how the count runs:

- **24-hour counting** runs from 00 to 23.
- **12-hour counting** runs from 12 through 11, with an AM/PM flag in bit 5.

When the count rolls over from the last hour of the day to midnight, the block raises a one-cycle day-carry pulse for the next stage.

A host can load the hour directly through a write strobe and an 8-bit value, and the stored value is always visible on the read output. The mode input only decides how the next increment is formed. Changing the mode never converts a value that is already stored, so software selects the mode before it writes the time.

Top module: `rtc_hour_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the stored hour becomes 0x12 (12 AM in 12-hour code) and `day_carry` becomes 0.
- R2: With `mode_24` = 1, each `hour_tick` advances the hour through the packed BCD codes 0x00, 0x01 … 0x09, 0x10 … 0x23, and after 0x23 it returns to 0x00.
- R3: With `mode_24` = 0, bit 5 is the PM flag. The count runs 0x12, 0x01 … 0x11 (AM), then 0x32, 0x21 … 0x31 (PM), then back to 0x12. The flag toggles on the step from hour 11 to hour 12.
- R4: `day_carry` is 1 for exactly the one cycle after a tick that wraps 0x23→0x00 (24-hour mode) or 0x31→0x12 (12-hour mode). At all other times it is 0.
- R5: A cycle with `wr_en` = 1 makes the read value equal to `wr_data` with bits 7:6 cleared, one cycle later. A write wins over an `hour_tick` in the same cycle, and that cycle raises no `day_carry`.
- R6: Changing `mode_24` leaves the stored hour unchanged. Only later ticks use the new mode.
- R7: A cycle with neither `hour_tick` nor `wr_en` leaves `rd_hour` unchanged.
- R8: Bits 7 and 6 of `rd_hour` always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hour_tick | input | 1 | One-cycle hour-carry strobe from the minutes stage |
| mode_24 | input | 1 | 1 = 24-hour counting, 0 = 12-hour counting with PM in bit 5 |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Hour value to load, packed BCD |
| rd_hour | output | 8 | Stored hour, packed BCD |
| day_carry | output | 1 | One-cycle pulse after a midnight wrap |

## Verification
The counter is stepped through a full day of 24 ticks in each mode. The bench compares every code with one computed from a plain hour index, which separates the BCD ones-to-tens carry from the 11→12 flag toggle and the two different wrap points. The day-carry output is checked after every one of those ticks, so a pulse on a wrong hour shows up as clearly as a missing one. Writes are tried with the upper bits set, alone and together with a tick on the wrap hour, which shows both masking and priority. A mode switch followed by an idle cycle shows that the stored value is not converted.

// File: rtl/rtc_hour_pkg.sv
// Package: shared widths and code constants for the hour counter.
// Assumes packed BCD hours held in an 8-bit field, with the top two bits unused.
package rtc_hour_pkg;
    localparam int HOUR_W    = 8;
    localparam int USED_W    = 6;
    localparam int PM_BIT    = 5;
    localparam int NIB_W     = 4;
    localparam logic [HOUR_W-1:0] RESET_CODE = 8'h12;
    localparam logic [USED_W-1:0] LAST_24    = 6'h23;
    localparam logic [PM_BIT-1:0] HR_ELEVEN  = 5'h11;
    localparam logic [PM_BIT-1:0] HR_TWELVE  = 5'h12;
    localparam logic [PM_BIT-1:0] HR_ONE     = 5'h01;
    localparam logic [NIB_W-1:0]  NIB_NINE   = 4'h9;
endpackage

// File: rtl/rtc_hour_step.sv
// Module: rtc_hour_step
// Combinational successor of a packed BCD hour in either counting mode.
// Assumes the input holds a valid code for the selected mode. Invalid codes
// still produce a defined BCD-style increment.
module rtc_hour_step
    import rtc_hour_pkg::*;
(
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic              mode_24,
    output logic [HOUR_W-1:0] next_hour,
    output logic              wraps
);
    logic              pm_flag;
    logic [PM_BIT-1:0] hr12;

    assign pm_flag = cur_hour[PM_BIT];
    assign hr12    = cur_hour[PM_BIT-1:0];

    // Purpose: pick the next code and flag the midnight wrap.
    always_comb begin
        next_hour = '0;
        wraps     = 1'b0;
        if (mode_24) begin
            if (cur_hour[USED_W-1:0] == LAST_24) begin
                next_hour = '0;
                wraps     = 1'b1;
            end else if (cur_hour[NIB_W-1:0] >= NIB_NINE) begin
                next_hour[USED_W-1:NIB_W] = cur_hour[USED_W-1:NIB_W] + 1'b1;
            end else begin
                next_hour[USED_W-1:0] = {cur_hour[USED_W-1:NIB_W], cur_hour[NIB_W-1:0] + 1'b1};
            end
        end else begin
            if (hr12 == HR_ELEVEN) begin
                next_hour[PM_BIT]     = ~pm_flag;
                next_hour[PM_BIT-1:0] = HR_TWELVE;
                wraps                 = pm_flag;
            end else if (hr12 == HR_TWELVE) begin
                next_hour[PM_BIT]     = pm_flag;
                next_hour[PM_BIT-1:0] = HR_ONE;
            end else if (hr12[NIB_W-1:0] >= NIB_NINE) begin
                next_hour[PM_BIT]     = pm_flag;
                next_hour[NIB_W]      = 1'b1;
            end else begin
                next_hour[PM_BIT]      = pm_flag;
                next_hour[NIB_W]       = hr12[NIB_W];
                next_hour[NIB_W-1:0]   = hr12[NIB_W-1:0] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_hour_store.sv
// Module: rtc_hour_store
// Holds the hour register and the registered day-carry pulse.
// Assumes a synchronous active-low reset. A host write wins over a tick.
module rtc_hour_store
    import rtc_hour_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [HOUR_W-1:0] load_val,
    input  logic [HOUR_W-1:0] step_val,
    input  logic              step_wraps,
    output logic [HOUR_W-1:0] hour_q,
    output logic              carry_q
);
    // Purpose: update the stored hour and the day-carry flag once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hour_q  <= RESET_CODE;
            carry_q <= 1'b0;
        end else if (load) begin
            hour_q  <= {{(HOUR_W-USED_W){1'b0}}, load_val[USED_W-1:0]};
            carry_q <= 1'b0;
        end else if (tick) begin
            hour_q  <= step_val;
            carry_q <= step_wraps;
        end else begin
            carry_q <= 1'b0;
        end
    end

    // R5: a write is taken in full on the next edge.
    a_r5_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> hour_q == {{(HOUR_W-USED_W){1'b0}}, $past(load_val[USED_W-1:0])});

    // R4: the carry only follows a tick that was not overridden by a write.
    a_r4_carry_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carry_q) |-> $past(tick) && !$past(load));
endmodule

// File: rtl/rtc_hour_counter.sv
// Module: rtc_hour_counter
// Hours stage of a real-time clock: BCD counting in 12- or 24-hour mode,
// a host load port and a day-carry pulse. Assumes hour_tick is a one-cycle strobe.
module rtc_hour_counter
    import rtc_hour_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hour_tick,
    input  logic              mode_24,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_hour,
    output logic              day_carry
);
    logic [HOUR_W-1:0] step_val;
    logic              step_wraps;

    rtc_hour_step step_i (
        .cur_hour  (rd_hour),
        .mode_24   (mode_24),
        .next_hour (step_val),
        .wraps     (step_wraps)
    );

    rtc_hour_store store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (hour_tick),
        .load       (wr_en),
        .load_val   (wr_data),
        .step_val   (step_val),
        .step_wraps (step_wraps),
        .hour_q     (rd_hour),
        .carry_q    (day_carry)
    );

    // R7: idle cycles keep the hour.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hour_tick && !wr_en |=> $stable(rd_hour));

    // R2: the 24-hour wrap goes to zero and raises the carry.
    a_r2_wrap_24: assert property (@(posedge clk) disable iff (!rst_n)
        hour_tick && !wr_en && mode_24 && rd_hour == 8'h23 |=> rd_hour == 8'h00 && day_carry);

    // R3: the step from 11 to 12 flips the PM flag.
    a_r3_pm_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        hour_tick && !wr_en && !mode_24 && rd_hour[4:0] == 5'h11
        |=> rd_hour[4:0] == 5'h12 && rd_hour[5] != $past(rd_hour[5]));

    // R4: the carry never lasts two cycles unless two wrapping ticks are back to back.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        day_carry && !hour_tick |=> !day_carry);

    // R8: the top bits of the read value stay clear.
    a_r8_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hour[7:6] == 2'b00);
endmodule

// File: tb/rtc_hour_counter_tb_top.sv
module rtc_hour_counter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hour_tick = 1'b0;
    logic       mode_24 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_hour;
    logic       day_carry;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    rtc_hour_counter dut_i (
        .clk(clk), .rst_n(rst_n), .hour_tick(hour_tick), .mode_24(mode_24),
        .wr_en(wr_en), .wr_data(wr_data), .rd_hour(rd_hour), .day_carry(day_carry)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    // Expected code of hour index h (0..23) in the selected mode.
    function automatic logic [7:0] code_of(input int h, input bit m24);
        int disp;
        if (m24) return to_bcd(h);
        disp = (h % 12 == 0) ? 12 : h % 12;
        return to_bcd(disp) | ((h >= 12) ? 8'h20 : 8'h00);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_tick();
        hour_tick = 1'b1;
        @(negedge clk);
        hour_tick = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] v, input bit with_tick);
        wr_en = 1'b1; wr_data = v; hour_tick = with_tick;
        @(negedge clk);
        wr_en = 1'b0; hour_tick = 1'b0;
    endtask

    initial begin
        repeat (500000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset value
        check("R1", rd_hour, 8'h12);
        check("R1", day_carry, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7", rd_hour, 8'h12);

        // R3 / R4: full 12-hour day from reset
        mode_24 = 1'b0;
        for (int i = 1; i <= 24; i++) begin
            do_tick();
            check("R3", rd_hour, code_of(i % 24, 1'b0));
            check("R4", day_carry, (i == 24) ? 1 : 0);
        end
        @(negedge clk);
        check("R4", day_carry, 0);

        // R2 / R4: full 24-hour day starting from a loaded 0x00
        mode_24 = 1'b1;
        do_write(8'h00, 1'b0);
        check("R5", rd_hour, 8'h00);
        for (int i = 1; i <= 24; i++) begin
            do_tick();
            check("R2", rd_hour, code_of(i % 24, 1'b1));
            check("R4", day_carry, (i == 24) ? 1 : 0);
        end

        // R5 / R8: writes with upper bits set are masked
        for (int i = 0; i < 24; i++) begin
            do_write(code_of(i, 1'b1) | 8'hC0, 1'b0);
            check("R8", rd_hour, code_of(i, 1'b1));
        end

        // R5: write wins over a wrapping tick, no carry
        do_write(8'h23, 1'b0);
        do_write(8'h07, 1'b1);
        check("R5", rd_hour, 8'h07);
        check("R5", day_carry, 0);

        // R6: mode change leaves the value; next tick uses new mode
        mode_24 = 1'b0;
        do_write(8'h31, 1'b0);
        mode_24 = 1'b1;
        @(negedge clk);
        check("R6", rd_hour, 8'h31);
        mode_24 = 1'b0;
        @(negedge clk);
        check("R6", rd_hour, 8'h31);
        do_tick();
        check("R6", rd_hour, 8'h12);
        check("R4", day_carry, 1);

        // R7: idle cycles hold
        repeat (3) @(negedge clk);
        check("R7", rd_hour, 8'h12);
        check("R7", day_carry, 0);

        // R1: reset mid-count
        do_tick();
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", rd_hour, 8'h12);
        rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule